// File: doc/BRIEF.md
# ULPI PHY Register Access Viewport

This block gives software an indirect path to the register set of a ULPI transceiver. One 32-bit word on a simple host register bus holds a command: a start bit for a register access, a start bit for a wakeup, a direction select, a port select, a six-bit PHY register address and a byte of write data. When software sets a start bit, a small engine drives the matching sequence on the 8-bit ULPI bus. A read lands its byte in a read-only field of the same word. The engine clears the start bit when it finishes, so software polls the word until the bit drops.

The word also shows a flag that reports whether the selected port is in normal synchronous operation. When the interface is marked disabled, the whole word reads as zero. Only one command runs at a time, and the word ignores every host write while a command is pending.

Top module: `ulpi_viewport`

## Requirements
- R1: After reset the word reads 0x00000000 (interface enabled), and ulpi_stp and ulpi_data_oe are low.
- R2: With if_enable low, a read of the word returns zero whatever fields are stored. The stored fields are kept and show again once if_enable returns high.
- R3: A write command (bit 30 set, bit 29 = 1) drives {2'b10, addr[5:0]} on ulpi_data_out starting the second cycle after the host write. It holds that byte until ulpi_nxt is seen, then drives the write byte (bits 7:0) for one cycle, then drives 0x00 with ulpi_stp high for one cycle. Bit 30 reads 0 in the following cycle.
- R4: A read command (bit 30 set, bit 29 = 0) drives {2'b11, addr[5:0]} until ulpi_nxt, then releases the bus. It waits for ulpi_dir high and treats the first dir-high cycle as turnaround. It captures ulpi_data_in on the second dir-high cycle into bits 15:8. Bit 30 clears one cycle after ulpi_dir is seen low again.
- R5: While bit 30 or bit 31 is set, host writes have no effect on any field, including writes of zero to the start bits.
- R6: A wakeup (bit 31 set) holds ulpi_stp high from the second cycle after the write until ulpi_dir is seen low. ulpi_stp then drops, and bit 31 clears in the same cycle.
- R7: A host write with bits 31 and 30 both set starts only the wakeup. Bit 30 reads 0, and no command byte is driven.
- R8: If ulpi_dir is high when a register access is pending, the engine keeps ulpi_data_oe low until dir falls. The command byte appears in the cycle after dir is seen low.
- R9: If ulpi_dir rises while the command or write byte is being driven, the engine releases the bus at once. It restarts the command byte in the cycle after dir is seen low.
- R10: Ports 0 and 1 are valid. A register access with port field (bits 26:24) of 2..7 completes in the cycle after it is stored, with no bus activity.
- R11: Bit 27 reads port_sync[port] for port 0 or 1 and reads 0 for any other port value. ulpi_port_sel carries the low bit of the stored port field.
- R12: ulpi_data_oe is never high while ulpi_dir is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_enable | input | 1 | Interface enabled; gates the read-back |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host byte address; the word sits at VP_OFFSET (0x170) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, zero when not addressed |
| port_sync | input | NPORTS | Per-port normal-synchronous-mode indication |
| ulpi_port_sel | output | PSEL_W | Selected PHY attachment |
| ulpi_dir | input | 1 | PHY owns the data bus |
| ulpi_nxt | input | 1 | PHY throttle / accept |
| ulpi_data_in | input | 8 | Data from PHY |
| ulpi_data_out | output | 8 | Data to PHY |
| ulpi_data_oe | output | 1 | Link drives the data bus |
| ulpi_stp | output | 1 | Stop / wake request to PHY |

## Verification
A stuck engine state shows at the ports as a start bit that never clears, or as a command byte that stays on ulpi_data_out after nxt. Both are visible within one or two cycles of the expected handshake. A wrong capture or turnaround count puts the wrong byte in bits 15:8, which a read of the word shows as soon as bit 30 drops. A faulty busy guard lets a mid-command host write change the address or clear a start bit, and the next read-back shows the changed field.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int WU_BIT   = 31;
  localparam int RUN_BIT  = 30;
  localparam int RW_BIT   = 29;
  localparam int SYNC_BIT = 27;
  localparam int PORT_LSB = 24;
  localparam int PORT_W   = 3;
  localparam int ADDR_LSB = 16;
  localparam int RD_LSB   = 8;
  localparam int WD_LSB   = 0;
  localparam int REGA_W   = 6;

  localparam logic [1:0] TXCMD_WR = 2'b10;
  localparam logic [1:0] TXCMD_RD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDATA, ST_STP, ST_RWAIT, ST_RCAP, ST_RFALL, ST_WAKE
  } eng_state_t;
endpackage

// File: rtl/ulpi_vp_regs.sv
module ulpi_vp_regs
  import ulpi_vp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int VP_OFFSET = 'h170,
  parameter int NPORTS    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   if_enable,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [NPORTS-1:0]      port_sync,
  input  logic                   eng_done,
  input  logic                   eng_cap,
  input  logic [BYTE_W-1:0]      cap_byte,
  output logic                   wu_q,
  output logic                   run_q,
  output logic                   rw_q,
  output logic [PORT_W-1:0]      port_q,
  output logic                   port_valid,
  output logic [BYTE_W-1:0]      addr_q,
  output logic [BYTE_W-1:0]      wd_q,
  output logic [BYTE_W-1:0]      rd_q
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(VP_OFFSET);

  logic hit, busy, accept, sync_flag;
  logic wu_d, run_d, rw_d;
  logic [PORT_W-1:0] port_d;
  logic [BYTE_W-1:0] addr_d, wd_d, rd_d;
  logic cmd_en, cap_en;

  assign hit    = (bus_addr == HIT_ADDR);
  assign busy   = wu_q | run_q;
  assign accept = bus_wr & hit & ~busy;
  assign cmd_en = accept | eng_done;
  assign cap_en = eng_cap;

  always_comb begin
    wu_d   = wu_q;
    run_d  = run_q;
    rw_d   = rw_q;
    port_d = port_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    if (accept) begin
      wu_d   = bus_wdata[WU_BIT];
      run_d  = bus_wdata[RUN_BIT] & ~bus_wdata[WU_BIT];
      rw_d   = bus_wdata[RW_BIT];
      port_d = bus_wdata[PORT_LSB +: PORT_W];
      addr_d = bus_wdata[ADDR_LSB +: BYTE_W];
      wd_d   = bus_wdata[WD_LSB +: BYTE_W];
    end
    if (eng_done) begin
      wu_d  = 1'b0;
      run_d = 1'b0;
    end
    if (eng_cap) rd_d = cap_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wu_q   <= 1'b0;
      run_q  <= 1'b0;
      rw_q   <= 1'b0;
      port_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cmd_en) begin
      wu_q   <= wu_d;
      run_q  <= run_d;
      rw_q   <= rw_d;
      port_q <= port_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= rd_d;
  end

  always_comb begin
    sync_flag  = 1'b0;
    port_valid = 1'b0;
    for (int i = 0; i < NPORTS; i++) begin
      if (port_q == PORT_W'(i)) begin
        sync_flag  = port_sync[i];
        port_valid = 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit && if_enable) begin
      bus_rdata[WU_BIT]                 = wu_q;
      bus_rdata[RUN_BIT]                = run_q;
      bus_rdata[RW_BIT]                 = rw_q;
      bus_rdata[SYNC_BIT]               = sync_flag;
      bus_rdata[PORT_LSB +: PORT_W]     = port_q;
      bus_rdata[ADDR_LSB +: BYTE_W]     = addr_q;
      bus_rdata[RD_LSB +: BYTE_W]       = rd_q;
      bus_rdata[WD_LSB +: BYTE_W]       = wd_q;
    end
  end
endmodule

// File: rtl/ulpi_vp_engine.sv
module ulpi_vp_engine
  import ulpi_vp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wu_q,
  input  logic               run_q,
  input  logic               rw_q,
  input  logic               port_valid,
  input  logic [REGA_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0]  wr_byte,
  input  logic               ulpi_dir,
  input  logic               ulpi_nxt,
  output logic [BYTE_W-1:0]  ulpi_data_out,
  output logic               ulpi_data_oe,
  output logic               ulpi_stp,
  output logic               eng_done,
  output logic               eng_cap
);
  eng_state_t st_q, st_d;
  logic drive;
  logic [1:0] txcmd;

  assign txcmd = rw_q ? TXCMD_WR : TXCMD_RD;

  always_comb begin
    st_d          = st_q;
    drive         = 1'b0;
    ulpi_data_out = '0;
    ulpi_stp      = 1'b0;
    eng_done      = 1'b0;
    eng_cap       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (wu_q)                st_d = ST_WAKE;
        else if (run_q) begin
          if (!port_valid)       eng_done = 1'b1;
          else if (!ulpi_dir)    st_d = ST_CMD;
        end
      end
      ST_CMD: begin
        drive         = 1'b1;
        ulpi_data_out = {txcmd, reg_addr};
        if (ulpi_dir)            st_d = ST_IDLE;
        else if (ulpi_nxt)       st_d = rw_q ? ST_WDATA : ST_RWAIT;
      end
      ST_WDATA: begin
        drive         = 1'b1;
        ulpi_data_out = wr_byte;
        st_d          = ulpi_dir ? ST_IDLE : ST_STP;
      end
      ST_STP: begin
        drive    = 1'b1;
        ulpi_stp = 1'b1;
        eng_done = 1'b1;
        st_d     = ST_IDLE;
      end
      ST_RWAIT: begin
        if (ulpi_dir)            st_d = ST_RCAP;
      end
      ST_RCAP: begin
        eng_cap = 1'b1;
        st_d    = ST_RFALL;
      end
      ST_RFALL: begin
        if (!ulpi_dir) begin
          eng_done = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      ST_WAKE: begin
        ulpi_stp = 1'b1;
        if (!ulpi_dir) begin
          eng_done = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ulpi_data_oe = drive & ~ulpi_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/ulpi_viewport.sv
module ulpi_viewport
  import ulpi_vp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int VP_OFFSET = 'h170,
  parameter int NPORTS    = 2,
  localparam int PSEL_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_enable,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPORTS-1:0]  port_sync,
  output logic [PSEL_W-1:0]  ulpi_port_sel,
  input  logic               ulpi_dir,
  input  logic               ulpi_nxt,
  input  logic [7:0]         ulpi_data_in,
  output logic [7:0]         ulpi_data_out,
  output logic               ulpi_data_oe,
  output logic               ulpi_stp
);
  logic rst_meta, rst_sync_n;
  logic wu_q, run_q, rw_q, port_valid, eng_done, eng_cap;
  logic [PORT_W-1:0] port_q;
  logic [BYTE_W-1:0] addr_q, wd_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ulpi_vp_regs #(
    .ADDR_W(ADDR_W), .VP_OFFSET(VP_OFFSET), .NPORTS(NPORTS)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .if_enable(if_enable),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_sync(port_sync),
    .eng_done(eng_done), .eng_cap(eng_cap), .cap_byte(ulpi_data_in),
    .wu_q(wu_q), .run_q(run_q), .rw_q(rw_q), .port_q(port_q),
    .port_valid(port_valid), .addr_q(addr_q), .wd_q(wd_q), .rd_q(rd_q)
  );

  ulpi_vp_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .wu_q(wu_q), .run_q(run_q), .rw_q(rw_q),
    .port_valid(port_valid), .reg_addr(addr_q[REGA_W-1:0]), .wr_byte(wd_q),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp),
    .eng_done(eng_done), .eng_cap(eng_cap)
  );

  assign ulpi_port_sel = port_q[PSEL_W-1:0];
endmodule

// File: rtl/ulpi_vp_chk.sv
module ulpi_vp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir,
  input logic       oe,
  input logic       stp,
  input logic       run_q,
  input logic       wu_q,
  input logic       done,
  input logic       cap,
  input logic [7:0] cap_byte,
  input logic [7:0] rd_q
);
  p_oe_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> !oe);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wu_q) |-> (!oe && !stp));

  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> run_q);

  p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wu_q && !done) |=> wu_q);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && wu_q));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (rd_q == $past(cap_byte)));

  p_stp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && run_q) |=> !stp);
endmodule

bind ulpi_viewport ulpi_vp_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dir(ulpi_dir), .oe(ulpi_data_oe),
  .stp(ulpi_stp), .run_q(run_q), .wu_q(wu_q), .done(eng_done),
  .cap(eng_cap), .cap_byte(ulpi_data_in), .rd_q(rd_q)
);

// File: tb/sim_ulpi_viewport.sv
module sim_ulpi_viewport;
  localparam logic [11:0] VA = 12'h170;

  logic clk = 1'b0;
  logic rst_n, if_enable, bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  port_sync;
  logic [0:0]  ulpi_port_sel;
  logic ulpi_dir, ulpi_nxt, ulpi_data_oe, ulpi_stp;
  logic [7:0] ulpi_data_in, ulpi_data_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ulpi_viewport u0 (
    .clk(clk), .rst_n(rst_n), .if_enable(if_enable), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .port_sync(port_sync), .ulpi_port_sel(ulpi_port_sel),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_data_in(ulpi_data_in),
    .ulpi_data_out(ulpi_data_out), .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [31:0] d);
    bus_addr = VA; bus_wdata = d; bus_wr = 1'b1;
    adv();
    bus_wr = 1'b0;
  endtask

  task automatic hread(output logic [31:0] d);
    bus_addr = VA; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] cmdw(input logic wu, input logic run, input logic rw,
                                       input logic [2:0] p, input logic [7:0] a,
                                       input logic [7:0] wd);
    return {wu, run, rw, 1'b0, 1'b0, p, a, 8'h00, wd};
  endfunction

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // R3: full write sequence with one cycle of nxt delay
  task automatic write_txn(input logic [7:0] a, input logic [7:0] wd);
    logic [31:0] r;
    hwrite(cmdw(1'b0, 1'b1, 1'b1, 3'd0, a, wd));
    hread(r); chk("R3 run set", {31'b0, r[30]}, 32'd1);
    chk("R3 idle oe", {31'b0, ulpi_data_oe}, 32'd0);
    adv();
    chk("R3 txcmd", {23'b0, ulpi_data_oe, ulpi_data_out}, {23'b0, 1'b1, 2'b10, a[5:0]});
    adv();
    chk("R3 txcmd held", {24'b0, ulpi_data_out}, {24'b0, 2'b10, a[5:0]});
    ulpi_nxt = 1'b1;
    adv();
    ulpi_nxt = 1'b0;
    chk("R3 wdata", {22'b0, ulpi_data_oe, ulpi_stp, ulpi_data_out}, {22'b0, 1'b1, 1'b0, wd});
    adv();
    chk("R3 stp", {22'b0, ulpi_data_oe, ulpi_stp, ulpi_data_out}, {22'b0, 1'b1, 1'b1, 8'h00});
    hread(r); chk("R3 run still set at stp", {31'b0, r[30]}, 32'd1);
    adv();
    hread(r);
    chk("R3 run cleared", {29'b0, r[30], ulpi_stp, ulpi_data_oe}, 32'd0);
  endtask

  // R4: full read sequence
  task automatic read_txn(input logic [7:0] a, input logic [7:0] phy_byte, input logic busy_poke);
    logic [31:0] r;
    hwrite(cmdw(1'b0, 1'b1, 1'b0, 3'd0, a, 8'h00));
    adv();
    chk("R4 txcmd", {23'b0, ulpi_data_oe, ulpi_data_out}, {23'b0, 1'b1, 2'b11, a[5:0]});
    ulpi_nxt = 1'b1;
    adv();
    ulpi_nxt = 1'b0;
    chk("R4 bus released", {31'b0, ulpi_data_oe}, 32'd0);
    ulpi_dir = 1'b1;
    if (busy_poke) begin
      hwrite(32'h0000_0000);
      hread(r);
      chk("R5 run kept under write", {31'b0, r[30]}, 32'd1);
      chk("R5 addr kept under write", {24'b0, r[23:16]}, {24'b0, a});
    end else adv();
    ulpi_data_in = phy_byte;
    adv();
    ulpi_data_in = 8'h00;
    ulpi_dir = 1'b0;
    hread(r);
    chk("R4 captured byte", {24'b0, r[15:8]}, {24'b0, phy_byte});
    chk("R4 run held during dir", {31'b0, r[30]}, 32'd1);
    adv();
    hread(r);
    chk("R4 run cleared", {31'b0, r[30]}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; if_enable = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = VA; bus_wdata = '0; port_sync = 2'b00;
    ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_in = 8'h00;
    repeat (3) adv();
    rst_n = 1'b1;
    repeat (3) adv();

    // R1
    hread(r);
    chk("R1 reset word", r, 32'h0);
    chk("R1 reset pins", {30'b0, ulpi_stp, ulpi_data_oe}, 32'd0);

    // R3 sweep
    for (int i = 0; i < 4; i++) write_txn(8'(8'h05 + i * 17), 8'(8'hA5 ^ (i * 8'h3C)));
    // R4 sweep, R5 with a mid-command write
    for (int i = 0; i < 4; i++) read_txn(8'(8'h11 + i * 9), 8'(8'h3C + i * 8'h41), i == 1);

    // R8: dir high at start
    ulpi_dir = 1'b1;
    hwrite(cmdw(1'b0, 1'b1, 1'b1, 3'd0, 8'h2A, 8'h77));
    repeat (3) begin
      adv();
      chk("R8 no drive while dir", {31'b0, ulpi_data_oe}, 32'd0);
    end
    ulpi_dir = 1'b0;
    adv();
    chk("R8 cmd after dir low", {23'b0, ulpi_data_oe, ulpi_data_out}, {23'b0, 1'b1, 8'hAA});
    // R9: dir rises mid-command
    ulpi_dir = 1'b1;
    #1 chk("R9 release at once", {31'b0, ulpi_data_oe}, 32'd0);
    adv();
    chk("R9 stays released", {31'b0, ulpi_data_oe}, 32'd0);
    ulpi_dir = 1'b0;
    adv();
    chk("R9 retry cmd", {23'b0, ulpi_data_oe, ulpi_data_out}, {23'b0, 1'b1, 8'hAA});
    ulpi_nxt = 1'b1;
    adv();
    ulpi_nxt = 1'b0;
    chk("R9 wdata after retry", {24'b0, ulpi_data_out}, 32'h77);
    adv(); adv();
    hread(r);
    chk("R9 run cleared", {31'b0, r[30]}, 32'd0);

    // R6: wakeup from low power
    ulpi_dir = 1'b1;
    hwrite(cmdw(1'b1, 1'b0, 1'b0, 3'd1, 8'h00, 8'h00));
    adv();
    for (int k = 0; k < 3; k++) begin
      hread(r);
      chk("R6 stp held while dir", {30'b0, ulpi_stp, r[31]}, 32'd3);
      adv();
    end
    ulpi_dir = 1'b0;
    adv();
    hread(r);
    chk("R6 wakeup done", {30'b0, ulpi_stp, r[31]}, 32'd0);

    // R7: both start bits
    hwrite(cmdw(1'b1, 1'b1, 1'b1, 3'd0, 8'h3F, 8'h12));
    hread(r);
    chk("R7 only wakeup set", {30'b0, r[31:30]}, 32'd2);
    adv();
    chk("R7 stp not oe", {30'b0, ulpi_stp, ulpi_data_oe}, 32'd2);
    adv();
    hread(r);
    chk("R7 finished", {29'b0, r[31:30], ulpi_data_oe}, 32'd0);

    // R10: invalid port completes silently
    for (int p = 2; p < 8; p++) begin
      hwrite(cmdw(1'b0, 1'b1, 1'b1, 3'(p), 8'h01, 8'h02));
      hread(r);
      chk("R10 run stored", {31'b0, r[30]}, 32'd1);
      chk("R10 no drive", {30'b0, ulpi_data_oe, ulpi_stp}, 32'd0);
      adv();
      hread(r);
      chk("R10 run cleared", {29'b0, r[30], ulpi_data_oe, ulpi_stp}, 32'd0);
    end

    // R11: exhaustive port x sync sweep
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 4; s++) begin
        port_sync = 2'(s);
        hwrite(cmdw(1'b0, 1'b0, 1'b0, 3'(p), 8'h00, 8'h00));
        hread(r);
        chk("R11 sync flag", {31'b0, r[27]}, {31'b0, (p < 2) ? s[p] : 1'b0});
        chk("R11 port field", {29'b0, r[26:24]}, 32'(p));
        chk("R11 port select", {31'b0, ulpi_port_sel}, 32'(p & 1));
      end
    end

    // R2: disabled reads zero, fields survive
    port_sync = 2'b11;
    hwrite(cmdw(1'b0, 1'b0, 1'b1, 3'd1, 8'h5C, 8'hE1));
    if_enable = 1'b0;
    hread(r);
    chk("R2 disabled zero", r, 32'h0);
    if_enable = 1'b1;
    hread(r);
    chk("R2 restored", {r[31:16], r[7:0]}, {4'b0010, 1'b1, 3'd1, 8'h5C, 8'hE1});

    finish_sim();
  end
endmodule